// File: doc/BRIEF.md
# Converter Acquisition Loop Sequencer

This block runs on the host side of a byte-wide sampling converter and keeps it converting without software help. It produces chip-select, read and write strobes and an 8-bit write bus, and it watches two active-low status inputs from the converter: a ready line and a standby line. After reset it writes a two-byte setup (channel, acquisition code, start command) and then issues a pair of reads that launch the first conversion. Data from that launching pair is thrown away.

From then on the loop repeats. The sequencer waits for the converter to go busy and then become ready again. It reads the low result byte, then the high result byte, and presents a 13-bit sample with a one-cycle valid pulse. The second read of each pair also starts the next conversion. If the channel or acquisition inputs change, the new setup is written once the running conversion completes, before that conversion's result is read. A ready wait that lasts too long raises an error pulse and restarts from the setup writes.

Top module: `acq_loop_ctrl`

## Requirements
- R1: A bus access (chip-select falling) starts only if, in the cycle before, ready was low or standby was low. After the second read of a pair, no access starts until ready has gone high and come back low.
- R2: The first setup byte is {bit7=1, bit6=0, bits5:4=acquisition code, bits3:0=channel}, with the channel and code taken from the inputs when that write starts.
- R3: The second setup byte is 8'h08: start command 4'h8 in bits 3:0, and bits 7:4 all zero (sync-mode and width-select bits cleared).
- R4: Each access drives chip-select low for one cycle before the strobe falls. The strobe stays low exactly STROBE_W cycles, and chip-select stays low for one cycle after the strobe rises. Read and write strobes are never low together. The write-bus enable is high only inside write accesses.
- R5: After reset, the two setup writes are followed at once by a read pair whose data yields no sample. The first valid sample comes from the second read pair.
- R6: In each read pair the first read supplies sample bits 7:0 and the second read's bits 4:0 supply sample bits 12:8 (its bits 7:5 are ignored). The sample is shown with a valid pulse one cycle long.
- R7: When the channel or acquisition inputs differ from the values last written, both setup bytes are written after the running conversion finishes and before the next read. The read pair that follows still yields a valid sample.
- R8: If the combined wait for ready to rise and fall again reaches TIMEOUT cycles, err_timeout_o pulses for one cycle. The next access is the first setup byte, and the read pair after that setup yields no sample.
- R9: While reset is asserted, chip-select, read and write strobes are high, the write enable is low, and the valid and error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_chan_i | input | 4 | Requested channel |
| cfg_acq_i | input | 2 | Requested acquisition-time code |
| adc_rdy_n_i | input | 1 | Converter ready, active low |
| adc_stby_n_i | input | 1 | Converter standby, active low |
| bus_din_i | input | 8 | Read data from converter |
| bus_cs_n_o | output | 1 | Chip-select, active low |
| bus_rd_n_o | output | 1 | Read strobe, active low |
| bus_wr_n_o | output | 1 | Write strobe, active low |
| bus_oe_o | output | 1 | Enable for driving bus_dout_o onto the shared bus |
| bus_dout_o | output | 8 | Write data |
| smp_data_o | output | 13 | Assembled sample |
| smp_valid_o | output | 1 | One-cycle sample strobe |
| err_timeout_o | output | 1 | One-cycle ready-wait timeout pulse |

## Verification
The properties assume the converter changes ready only on clock edges and holds read data stable while the read strobe is low. They also assume that, once ready has been seen low, it stays low until the converter gets a second read or a start command. The bench converter model updates ready and data only at rising edges and raises ready only on a completed read pair. It changes the channel and acquisition inputs only while a conversion is running and ready is high, so a setup write never races an input change.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int CHAN_W = 4;
  localparam int ACQ_W  = 2;
  localparam int BYTE_W = 8;
  localparam int RES_W  = 13;
  localparam int HI_W   = RES_W - BYTE_W;
  localparam logic [3:0] CMD_START = 4'h8;

  typedef enum logic [2:0] {
    ST_CFG0,
    ST_CFG1,
    ST_RDLO,
    ST_RDHI,
    ST_WBUSY,
    ST_WDONE
  } ctl_st_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } acc_ph_e;

  function automatic logic [BYTE_W-1:0] setup_byte0(input logic [CHAN_W-1:0] chan,
                                                    input logic [ACQ_W-1:0] acq);
    setup_byte0 = {1'b1, 1'b0, acq, chan};
  endfunction

  function automatic logic [BYTE_W-1:0] setup_byte1();
    setup_byte1 = {4'b0000, CMD_START};
  endfunction
endpackage

// File: rtl/acq_rst_sync.sv
module acq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/acq_bus_cycle.sv
module acq_bus_cycle
  import acq_pkg::*;
#(
  parameter int STROBE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [BYTE_W-1:0] bus_din_i,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              oe_o,
  output logic [BYTE_W-1:0] dout_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              done_o,
  output logic              idle_o
);
  localparam int CW = (STROBE_W > 1) ? $clog2(STROBE_W + 1) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(STROBE_W - 1);

  acc_ph_e           ph_q, ph_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              wr_q, wr_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d;
  logic [BYTE_W-1:0] rdata_q, rdata_d;

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          ph_d    = PH_SETUP;
          wr_d    = write_i;
          wdata_d = wdata_i;
        end
      end
      PH_SETUP: begin
        ph_d  = PH_STROBE;
        cnt_d = '0;
      end
      PH_STROBE: begin
        if (cnt_q == CNT_LAST) begin
          ph_d = PH_HOLD;
          if (!wr_q) rdata_d = bus_din_i;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_HOLD: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

  assign cs_n_o  = (ph_q == PH_IDLE);
  assign rd_n_o  = !((ph_q == PH_STROBE) && !wr_q);
  assign wr_n_o  = !((ph_q == PH_STROBE) && wr_q);
  assign oe_o    = wr_q && (ph_q != PH_IDLE);
  assign dout_o  = wdata_q;
  assign rdata_o = rdata_q;
  assign done_o  = (ph_q == PH_HOLD);
  assign idle_o  = (ph_q == PH_IDLE);
endmodule

// File: rtl/acq_wait_timer.sv
module acq_wait_timer #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run_i)              cnt_d = '0;
    else if (cnt_q != LAST)  cnt_d = cnt_q + 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/acq_loop_ctrl.sv
module acq_loop_ctrl
  import acq_pkg::*;
#(
  parameter int STROBE_W = 3,
  parameter int TIMEOUT  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAN_W-1:0] cfg_chan_i,
  input  logic [ACQ_W-1:0]  cfg_acq_i,
  input  logic              adc_rdy_n_i,
  input  logic              adc_stby_n_i,
  input  logic [BYTE_W-1:0] bus_din_i,
  output logic              bus_cs_n_o,
  output logic              bus_rd_n_o,
  output logic              bus_wr_n_o,
  output logic              bus_oe_o,
  output logic [BYTE_W-1:0] bus_dout_o,
  output logic [RES_W-1:0]  smp_data_o,
  output logic              smp_valid_o,
  output logic              err_timeout_o
);
  logic srst_n;

  ctl_st_e           st_q, st_d;
  logic              issued_q, issued_d;
  logic              prime_q, prime_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic [ACQ_W-1:0]  acq_q, acq_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic [RES_W-1:0]  smp_q, smp_d;
  logic              vld_q, vld_d;
  logic              err_q, err_d;

  logic              bus_ok, acc_state, acc_start, acc_wr;
  logic [BYTE_W-1:0] acc_wdata, seq_rdata;
  logic              seq_done, seq_idle, wait_run, wait_exp, cfg_dirty;

  acq_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (srst_n)
  );

  acq_bus_cycle #(.STROBE_W(STROBE_W)) u_seq (
    .clk       (clk),
    .rst_n     (srst_n),
    .start_i   (acc_start),
    .write_i   (acc_wr),
    .wdata_i   (acc_wdata),
    .bus_din_i (bus_din_i),
    .cs_n_o    (bus_cs_n_o),
    .rd_n_o    (bus_rd_n_o),
    .wr_n_o    (bus_wr_n_o),
    .oe_o      (bus_oe_o),
    .dout_o    (bus_dout_o),
    .rdata_o   (seq_rdata),
    .done_o    (seq_done),
    .idle_o    (seq_idle)
  );

  acq_wait_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk      (clk),
    .rst_n    (srst_n),
    .run_i    (wait_run),
    .expire_o (wait_exp)
  );

  // Converter may be touched while ready is low, or while it sits in standby.
  assign bus_ok    = !adc_rdy_n_i || !adc_stby_n_i;
  assign acc_state = (st_q == ST_CFG0) || (st_q == ST_CFG1) ||
                     (st_q == ST_RDLO) || (st_q == ST_RDHI);
  assign acc_start = acc_state && !issued_q && seq_idle && bus_ok;
  assign acc_wr    = (st_q == ST_CFG0) || (st_q == ST_CFG1);
  assign acc_wdata = (st_q == ST_CFG0) ? setup_byte0(cfg_chan_i, cfg_acq_i) : setup_byte1();
  assign wait_run  = (st_q == ST_WBUSY) || (st_q == ST_WDONE);
  assign cfg_dirty = (cfg_chan_i != chan_q) || (cfg_acq_i != acq_q);

  always_comb begin
    st_d     = st_q;
    issued_d = issued_q;
    prime_d  = prime_q;
    chan_d   = chan_q;
    acq_d    = acq_q;
    lo_d     = lo_q;
    smp_d    = smp_q;
    vld_d    = 1'b0;
    err_d    = 1'b0;

    if (acc_start) begin
      issued_d = 1'b1;
      if (st_q == ST_CFG0) begin
        chan_d = cfg_chan_i;
        acq_d  = cfg_acq_i;
      end
    end

    unique case (st_q)
      ST_CFG0: if (seq_done) begin st_d = ST_CFG1; issued_d = 1'b0; end
      ST_CFG1: if (seq_done) begin st_d = ST_RDLO; issued_d = 1'b0; end
      ST_RDLO: if (seq_done) begin
        st_d     = ST_RDHI;
        issued_d = 1'b0;
        lo_d     = seq_rdata;
      end
      ST_RDHI: if (seq_done) begin
        st_d     = ST_WBUSY;
        issued_d = 1'b0;
        smp_d    = {seq_rdata[HI_W-1:0], lo_q};
        vld_d    = !prime_q;
        prime_d  = 1'b0;
      end
      ST_WBUSY: begin
        if (adc_rdy_n_i) st_d = ST_WDONE;
        else if (wait_exp) begin
          st_d    = ST_CFG0;
          err_d   = 1'b1;
          prime_d = 1'b1;
        end
      end
      ST_WDONE: begin
        if (!adc_rdy_n_i) st_d = cfg_dirty ? ST_CFG0 : ST_RDLO;
        else if (wait_exp) begin
          st_d    = ST_CFG0;
          err_d   = 1'b1;
          prime_d = 1'b1;
        end
      end
      default: st_d = ST_CFG0;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q     <= ST_CFG0;
      issued_q <= 1'b0;
      prime_q  <= 1'b1;
      chan_q   <= '0;
      acq_q    <= '0;
      lo_q     <= '0;
      smp_q    <= '0;
      vld_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      issued_q <= issued_d;
      prime_q  <= prime_d;
      chan_q   <= chan_d;
      acq_q    <= acq_d;
      lo_q     <= lo_d;
      smp_q    <= smp_d;
      vld_q    <= vld_d;
      err_q    <= err_d;
    end
  end

  assign smp_data_o    = smp_q;
  assign smp_valid_o   = vld_q;
  assign err_timeout_o = err_q;
endmodule

// File: rtl/acq_loop_ctrl_chk.sv
module acq_loop_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic adc_rdy_n_i,
  input logic adc_stby_n_i,
  input logic bus_cs_n_o,
  input logic bus_rd_n_o,
  input logic bus_wr_n_o,
  input logic bus_oe_o,
  input logic smp_valid_o,
  input logic err_timeout_o
);
  assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n_o) |-> $past(!adc_rdy_n_i || !adc_stby_n_i));

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n_o && !bus_wr_n_o));

  assert_strobe_in_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n_o || !bus_wr_n_o) |-> !bus_cs_n_o);

  assert_cs_lead_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd_n_o) |-> $past(!bus_cs_n_o));

  assert_cs_lead_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n_o) |-> $past(!bus_cs_n_o));

  assert_oe_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o |-> (!bus_cs_n_o && bus_rd_n_o));

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |=> !smp_valid_o);

  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout_o |=> !err_timeout_o);

  assert_err_bus_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout_o |-> bus_cs_n_o);
endmodule

bind acq_loop_ctrl acq_loop_ctrl_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .adc_rdy_n_i   (adc_rdy_n_i),
  .adc_stby_n_i  (adc_stby_n_i),
  .bus_cs_n_o    (bus_cs_n_o),
  .bus_rd_n_o    (bus_rd_n_o),
  .bus_wr_n_o    (bus_wr_n_o),
  .bus_oe_o      (bus_oe_o),
  .smp_valid_o   (smp_valid_o),
  .err_timeout_o (err_timeout_o)
);

// File: tb/acq_loop_ctrl_tb_top.sv
`timescale 1ns/1ps
module acq_loop_ctrl_tb_top;
  localparam int STROBE_W = 3;
  localparam int TIMEOUT  = 120;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cfg_chan;
  logic [1:0]  cfg_acq;
  logic        rdy_n, stby_n;
  logic [7:0]  bus_din, bus_dout;
  logic        cs_n, rd_n, wr_n, oe;
  logic [12:0] smp;
  logic        smp_valid, err;

  always #2.5 clk = ~clk;

  acq_loop_ctrl #(.STROBE_W(STROBE_W), .TIMEOUT(TIMEOUT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_chan_i(cfg_chan), .cfg_acq_i(cfg_acq),
    .adc_rdy_n_i(rdy_n), .adc_stby_n_i(stby_n), .bus_din_i(bus_din),
    .bus_cs_n_o(cs_n), .bus_rd_n_o(rd_n), .bus_wr_n_o(wr_n), .bus_oe_o(oe),
    .bus_dout_o(bus_dout), .smp_data_o(smp), .smp_valid_o(smp_valid),
    .err_timeout_o(err)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [7:0] exp_byte0(input logic [3:0] c, input logic [1:0] a);
    return {1'b1, 1'b0, a, c};
  endfunction

  // ---------------- converter model ----------------
  logic        hang_req;
  logic [12:0] res;
  logic        rd_par, wpar, rd_prev, wr_prev, disc, after_err;
  logic [7:0]  wlast;
  logic [5:0]  last_cfg;
  int          conv_cnt, pairs;
  logic [12:0] expq[$];

  assign bus_din = !rd_n ? (rd_par ? {3'b101, res[12:8]} : res[7:0]) : 8'h00;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_n <= 1'b0; rdy_n <= 1'b1; conv_cnt <= 0; res <= 13'h0abc;
      rd_par <= 1'b0; wpar <= 1'b0; rd_prev <= 1'b1; wr_prev <= 1'b1;
      disc <= 1'b1; pairs <= 0; wlast <= 8'h00; after_err <= 1'b0; last_cfg <= 6'h0;
    end else begin
      rd_prev <= rd_n;
      wr_prev <= wr_n;
      if (!wr_n) wlast <= bus_dout;
      if (wr_n && !wr_prev) begin
        if (after_err) begin
          chk(wpar == 1'b0, "R8 restart not at first setup byte", wpar, 0);
          after_err <= 1'b0;
        end
        if (!wpar) begin
          chk(wlast == exp_byte0(cfg_chan, cfg_acq), "R2 setup byte0", wlast, exp_byte0(cfg_chan, cfg_acq));
          last_cfg <= {cfg_chan, cfg_acq};
          wpar <= 1'b1;
        end else begin
          chk(wlast == 8'h08, "R3 setup byte1", wlast, 8'h08);
          wpar <= 1'b0;
          rd_par <= 1'b0;
          if (!stby_n) begin stby_n <= 1'b1; rdy_n <= 1'b0; end
        end
      end
      if (rd_n && !rd_prev) begin
        if (after_err) chk(1'b0, "R8 read before setup", 1, 0);
        chk(wpar == 1'b0, "R5 read between setup bytes", wpar, 0);
        chk(last_cfg == {cfg_chan, cfg_acq}, "R7 stale setup at read", last_cfg, {cfg_chan, cfg_acq});
        if (!rd_par) rd_par <= 1'b1;
        else begin
          rd_par <= 1'b0;
          pairs <= pairs + 1;
          if (!disc) expq.push_back(res);
          disc <= 1'b0;
          rdy_n <= 1'b1;
          conv_cnt <= 4 + int'($urandom % 37);
        end
      end else if (conv_cnt != 0) begin
        if (conv_cnt == 1) begin
          if (!hang_req) begin
            rdy_n <= 1'b0;
            res <= 13'($urandom);
            conv_cnt <= 0;
          end
        end else conv_cnt <= conv_cnt - 1;
      end
      if (err) begin
        rdy_n <= 1'b0; conv_cnt <= 0; disc <= 1'b1; after_err <= 1'b1;
      end
    end
  end

  // ---------------- output monitor ----------------
  logic p_cs = 1, p_rd = 1, p_wr = 1, p_ok = 0, first_vld = 0;
  int rd_cnt = 0, wr_cnt = 0, rdy_run = 0, nvalid = 0, nerr = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_cs && !cs_n) chk(p_ok, "R1 access while converter busy", 0, 1);
      if (p_rd && !rd_n) begin
        chk(!p_cs, "R4 cs lead before read", p_cs, 0);
        chk(wr_n && !oe, "R4 read overlaps write", {wr_n, oe}, 2);
      end
      if (p_wr && !wr_n) begin
        chk(!p_cs, "R4 cs lead before write", p_cs, 0);
        chk(rd_n && oe, "R4 write enable", {rd_n, oe}, 3);
      end
      if (!rd_n) rd_cnt++;
      if (!wr_n) wr_cnt++;
      if (!p_rd && rd_n) begin
        chk(rd_cnt == STROBE_W, "R4 read width", rd_cnt, STROBE_W);
        chk(!cs_n, "R4 cs hold after read", cs_n, 0);
        rd_cnt = 0;
      end
      if (!p_wr && wr_n) begin
        chk(wr_cnt == STROBE_W, "R4 write width", wr_cnt, STROBE_W);
        chk(!cs_n, "R4 cs hold after write", cs_n, 0);
        wr_cnt = 0;
      end
      if (rdy_n) rdy_run++; else rdy_run = 0;
      if (err) begin
        nerr++;
        chk(rdy_run >= TIMEOUT - 1 && rdy_run <= TIMEOUT + 3, "R8 timeout window", rdy_run, TIMEOUT + 1);
      end
      if (smp_valid) begin
        if (!first_vld) chk(pairs == 2, "R5 first sample from second pair", pairs, 2);
        first_vld = 1;
        if (expq.size() == 0) chk(1'b0, "R6 unexpected sample", smp, 0);
        else begin
          logic [12:0] e;
          e = expq.pop_front();
          chk(smp == e, "R6 sample value", smp, e);
        end
        nvalid++;
      end
    end
    p_cs = cs_n; p_rd = rd_n; p_wr = wr_n; p_ok = !rdy_n || !stby_n;
  end

  // ---------------- stimulus ----------------
  initial begin
    int base;
    bit directed;
    void'($urandom(32'd2024));
    cfg_chan = 4'd3; cfg_acq = 2'd1; hang_req = 1'b0; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(cs_n && rd_n && wr_n, "R9 strobes idle in reset", {cs_n, rd_n, wr_n}, 7);
    chk(!oe, "R9 write enable low in reset", oe, 0);
    chk(!smp_valid && !err, "R9 flags low in reset", {smp_valid, err}, 0);
    rst_n = 1'b1;

    directed = 0;
    while (nvalid < 40) begin
      @(negedge clk);
      if (rdy_n && stby_n && conv_cnt > 3 && !hang_req && ($urandom % 20 == 0)) begin
        if (!directed) begin cfg_chan = 4'hf; cfg_acq = 2'd3; directed = 1; end
        else begin
          cfg_chan = cfg_chan + 4'(1 + $urandom % 15);
          cfg_acq  = 2'($urandom);
        end
      end
    end

    // R8 directed: converter never completes
    do @(negedge clk); while (!(rdy_n == 1'b0 && stby_n == 1'b1));
    hang_req = 1'b1;
    while (nerr == 0) @(negedge clk);
    hang_req = 1'b0;
    base = nvalid;
    while (nvalid < base + 30) begin
      @(negedge clk);
      if (rdy_n && conv_cnt > 3 && ($urandom % 25 == 0)) cfg_acq = cfg_acq + 2'd1;
    end
    repeat (5) @(negedge clk);
    chk(nerr == 1, "R8 single timeout pulse", nerr, 1);
    chk(expq.size() == 0, "R6 samples missing", expq.size(), 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule